// File: doc/BRIEF.md
# Raster Operation Word Datapath

This block computes one destination word per step of a bit-block transfer. Source words come in one at a time and enter a two-word shift buffer. A programmable skew picks a 16-bit window out of that buffer, which aligns the source bits with the destination bits. The window can then be combined with a row of a 16-entry halftone pattern memory. The result is merged with the fetched destination word under any of the sixteen two-input Boolean functions. An end mask then decides, bit by bit, whether each output bit takes the computed value or keeps the destination bit.

A sequencer outside this block does the address generation and the bus traffic. For each destination word it pulses `src_shift` once for every source fetch, including the extra priming fetch and the suppressed final fetch. It then presents the destination word with `calc_en` high. The merged word appears on `new_dst` one clock later, with `new_dst_valid` high for that cycle. The halftone rows are written through a simple write port before a transfer starts.

Top module: `rop_datapath`

## Requirements
- R1: While reset is asserted and after it is released, `new_dst` is 0 and `new_dst_valid` is 0 until the first `calc_en` step.
- R2: A source step with `src_shift`=1, `src_fill`=1 and `src_rev`=0 moves the buffer's low 16 bits into its high 16 bits and loads `src_word` into the low 16 bits.
- R3: A source step with `src_rev`=1 and `src_fill`=1 moves the buffer's high 16 bits into its low 16 bits and loads `src_word` into the high 16 bits.
- R4: A source step with `src_fill`=0 still moves one half of the buffer into the other half according to `src_rev`. The half that would have received `src_word` keeps its previous contents.
- R5: The source operand is bits [15:0] of the 32-bit buffer shifted right by `skew` (0 to 15).
- R6: `hop` selects the source-side operand: 0 gives all ones, 1 gives the halftone row, 2 gives the skewed source, and 3 gives the skewed source AND the halftone row.
- R7: For each bit, with operand s and destination bit d, the result is `op[3]` when s=0,d=0, `op[2]` when s=0,d=1, `op[1]` when s=1,d=0 and `op[0]` when s=1,d=1.
- R8: A write with `ht_we`=1 stores `ht_wdata` in row `ht_waddr`. With `smudge`=0 the row used is the one that `line_num` selects.
- R9: With `smudge`=1 the row used is the one that bits [3:0] of the skewed source select, and `line_num` has no effect. The `hop` rule still applies.
- R10: Each bit of `new_dst` takes the logic result where `end_mask` is 1 and the bit of `dst_word` where `end_mask` is 0.
- R11: For `op` values 0, 3, C and F the value of `dst_word` has no effect on `new_dst`.
- R12: `new_dst` is updated only at a clock edge where `calc_en`=1, and holds its value otherwise. `new_dst_valid` is 1 exactly in the cycle after each `calc_en` step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_shift | input | 1 | Source buffer step strobe |
| src_fill | input | 1 | Load `src_word` on this step (0 = transfer halves only) |
| src_rev | input | 1 | Reverse buffer direction (right-to-left scan) |
| src_word | input | 16 | Fetched source word |
| skew | input | 4 | Right shift applied to the source buffer |
| hop | input | 2 | Source/halftone combination rule |
| op | input | 4 | Boolean rule of operand and destination |
| smudge | input | 1 | Select halftone row from the skewed source |
| line_num | input | 4 | Halftone row when smudge is off |
| ht_we | input | 1 | Halftone row write enable |
| ht_waddr | input | 4 | Halftone row to write |
| ht_wdata | input | 16 | Halftone row data |
| calc_en | input | 1 | Compute and register the output word |
| dst_word | input | 16 | Fetched destination word |
| end_mask | input | 16 | Bits of the destination to update |
| new_dst | output | 16 | Merged destination word |
| new_dst_valid | output | 1 | `new_dst` was updated on the last edge |

## Verification
The hardest case to reach is smudge mode. There, the halftone row address comes from the skewed source itself, so the buffer history, the skew and the halftone contents must all line up before the row can be observed. The bench first fills all sixteen rows with distinct values. It then shifts in a word pair whose low nibble differs under two skews from the line number that is applied at the same time. Any path that still uses `line_num`, or takes the nibble before the skew, returns a row that differs from the one expected. The reverse and flush-only buffer steps are reached in the same way, through chains of source steps that are followed by a pass-through calculation.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {
    HOP_ONES = 2'd0,
    HOP_HT   = 2'd1,
    HOP_SRC  = 2'd2,
    HOP_BOTH = 2'd3
  } hop_e;
endpackage

// File: rtl/rop_srcbuf.sv
module rop_srcbuf #(
  parameter int W = 16,
  localparam int BW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          fill,
  input  logic          rev,
  input  logic [W-1:0]  word,
  output logic [BW-1:0] sbuf_q
);
  logic [BW-1:0] sbuf_d;

  always_comb begin
    sbuf_d = sbuf_q;
    if (shift) begin
      if (!rev) begin
        sbuf_d = {sbuf_q[W-1:0], (fill ? word : sbuf_q[W-1:0])};
      end else begin
        sbuf_d = {(fill ? word : sbuf_q[BW-1:W]), sbuf_q[BW-1:W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sbuf_q <= '0;
    else        sbuf_q <= sbuf_d;
  end

  // R2
  property p_fwd;
    @(posedge clk) disable iff (!rst_n)
      (shift && fill && !rev) |=> (sbuf_q == {$past(sbuf_q[W-1:0]), $past(word)});
  endproperty
  fwd_load_chk: assert property (p_fwd);

  // R3
  property p_rev;
    @(posedge clk) disable iff (!rst_n)
      (shift && fill && rev) |=> (sbuf_q == {$past(word), $past(sbuf_q[BW-1:W])});
  endproperty
  rev_load_chk: assert property (p_rev);

  // R4
  property p_flush;
    @(posedge clk) disable iff (!rst_n)
      (shift && !fill && !rev) |=> (sbuf_q[BW-1:W] == $past(sbuf_q[W-1:0]) && $stable(sbuf_q[W-1:0]));
  endproperty
  flush_shift_chk: assert property (p_flush);

  // R2
  property p_idle;
    @(posedge clk) disable iff (!rst_n) !shift |=> $stable(sbuf_q);
  endproperty
  buf_idle_chk: assert property (p_idle);
endmodule

// File: rtl/rop_halftone.sv
module rop_halftone #(
  parameter int W = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

  // R8
  property p_wr;
    @(posedge clk) disable iff (!rst_n) we |=> (mem_q[$past(waddr)] == $past(wdata));
  endproperty
  ht_write_chk: assert property (p_wr);
endmodule

// File: rtl/rop_combine.sv
module rop_combine
  import rop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] ht,
  input  logic [W-1:0] dst,
  input  logic [1:0]   hop,
  input  logic [3:0]   op,
  input  logic [W-1:0] mask,
  output logic [W-1:0] result
);
  logic [W-1:0] opnd;
  logic [W-1:0] lres;

  always_comb begin
    case (hop_e'(hop))
      HOP_ONES: opnd = '1;
      HOP_HT:   opnd = ht;
      HOP_SRC:  opnd = src;
      default:  opnd = src & ht;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign lres[i]   = op[{~opnd[i], ~dst[i]}];
    assign result[i] = mask[i] ? lres[i] : dst[i];
  end
endmodule

// File: rtl/rop_datapath.sv
module rop_datapath #(
  parameter int W = 16,
  parameter int HT_DEPTH = 16,
  localparam int SKEW_W = $clog2(W),
  localparam int HT_AW = $clog2(HT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_shift,
  input  logic              src_fill,
  input  logic              src_rev,
  input  logic [W-1:0]      src_word,
  input  logic [SKEW_W-1:0] skew,
  input  logic [1:0]        hop,
  input  logic [3:0]        op,
  input  logic              smudge,
  input  logic [HT_AW-1:0]  line_num,
  input  logic              ht_we,
  input  logic [HT_AW-1:0]  ht_waddr,
  input  logic [W-1:0]      ht_wdata,
  input  logic              calc_en,
  input  logic [W-1:0]      dst_word,
  input  logic [W-1:0]      end_mask,
  output logic [W-1:0]      new_dst,
  output logic              new_dst_valid
);
  localparam int BW = 2 * W;

  logic [BW-1:0]    sbuf;
  logic [BW-1:0]    shifted;
  logic [W-1:0]     skewed;
  logic [HT_AW-1:0] ht_raddr;
  logic [W-1:0]     ht_word;
  logic [W-1:0]     result;
  logic [W-1:0]     dst_d;
  logic             vld_d;

  rop_srcbuf #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n), .shift(src_shift), .fill(src_fill),
    .rev(src_rev), .word(src_word), .sbuf_q(sbuf)
  );

  assign shifted  = sbuf >> skew;
  assign skewed   = shifted[W-1:0];
  assign ht_raddr = smudge ? skewed[HT_AW-1:0] : line_num;

  rop_halftone #(.W(W), .DEPTH(HT_DEPTH)) u_ht (
    .clk(clk), .rst_n(rst_n), .we(ht_we), .waddr(ht_waddr), .wdata(ht_wdata),
    .raddr(ht_raddr), .rdata(ht_word)
  );

  rop_combine #(.W(W)) u_cmb (
    .src(skewed), .ht(ht_word), .dst(dst_word), .hop(hop), .op(op),
    .mask(end_mask), .result(result)
  );

  always_comb begin
    dst_d = calc_en ? result : new_dst;
    vld_d = calc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_dst       <= '0;
      new_dst_valid <= 1'b0;
    end else begin
      new_dst       <= dst_d;
      new_dst_valid <= vld_d;
    end
  end

  // R10
  property p_mask;
    @(posedge clk) disable iff (!rst_n)
      calc_en |=> (((new_dst ^ $past(dst_word)) & ~$past(end_mask)) == '0);
  endproperty
  mask_keep_chk: assert property (p_mask);

  // R12
  property p_hold;
    @(posedge clk) disable iff (!rst_n) !calc_en |=> $stable(new_dst);
  endproperty
  out_hold_chk: assert property (p_hold);

  // R7
  property p_zero;
    @(posedge clk) disable iff (!rst_n)
      (calc_en && op == 4'h0) |=> ((new_dst & $past(end_mask)) == '0);
  endproperty
  op_zero_chk: assert property (p_zero);

  // R7
  property p_ones;
    @(posedge clk) disable iff (!rst_n)
      (calc_en && op == 4'hF) |=> ((~new_dst & $past(end_mask)) == '0);
  endproperty
  op_ones_chk: assert property (p_ones);
endmodule

// File: tb/sim_rop_datapath.sv
module sim_rop_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_shift, src_fill, src_rev;
  logic [15:0] src_word;
  logic [3:0]  skew;
  logic [1:0]  hop;
  logic [3:0]  op;
  logic        smudge;
  logic [3:0]  line_num;
  logic        ht_we;
  logic [3:0]  ht_waddr;
  logic [15:0] ht_wdata;
  logic        calc_en;
  logic [15:0] dst_word, end_mask;
  logic [15:0] new_dst;
  logic        new_dst_valid;

  int checks = 0;
  int fails = 0;
  logic [31:0] bm;
  logic [15:0] htm [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rop_datapath u0 (
    .clk(clk), .rst_n(rst_n), .src_shift(src_shift), .src_fill(src_fill),
    .src_rev(src_rev), .src_word(src_word), .skew(skew), .hop(hop), .op(op),
    .smudge(smudge), .line_num(line_num), .ht_we(ht_we), .ht_waddr(ht_waddr),
    .ht_wdata(ht_wdata), .calc_en(calc_en), .dst_word(dst_word),
    .end_mask(end_mask), .new_dst(new_dst), .new_dst_valid(new_dst_valid)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [15:0] d, logic [15:0] m);
    logic [31:0] sh;
    logic [15:0] s, h, o, r;
    sh = bm >> skew;
    s = sh[15:0];
    h = smudge ? htm[s[3:0]] : htm[line_num];
    case (hop)
      2'd0: o = 16'hFFFF;
      2'd1: o = h;
      2'd2: o = s;
      default: o = s & h;
    endcase
    for (int i = 0; i < 16; i++) begin
      if (!o[i] && !d[i])     r[i] = op[3];
      else if (!o[i] && d[i]) r[i] = op[2];
      else if (o[i] && !d[i]) r[i] = op[1];
      else                    r[i] = op[0];
      if (!m[i]) r[i] = d[i];
    end
    return r;
  endfunction

  task automatic shift_in(logic [15:0] w, logic fl, logic rv);
    @(negedge clk);
    src_shift = 1'b1; src_fill = fl; src_rev = rv; src_word = w;
    @(negedge clk);
    src_shift = 1'b0;
    if (!rv) bm = {bm[15:0], (fl ? w : bm[15:0])};
    else     bm = {(fl ? w : bm[31:16]), bm[31:16]};
  endtask

  task automatic calc(string req, logic [15:0] d, logic [15:0] m);
    logic [15:0] e;
    e = model(d, m);
    @(negedge clk);
    calc_en = 1'b1; dst_word = d; end_mask = m;
    @(negedge clk);
    calc_en = 1'b0;
    check(req, new_dst, e);
    check(req, {15'd0, new_dst_valid}, 16'd1);
  endtask

  task automatic set_cfg(logic [3:0] sk, logic [1:0] hp, logic [3:0] o, logic sm, logic [3:0] ln);
    skew = sk; hop = hp; op = o; smudge = sm; line_num = ln;
  endtask

  task automatic t_reset;
    check("R1 reset data", new_dst, 16'h0000);
    check("R1 reset valid", {15'd0, new_dst_valid}, 16'd0);
  endtask

  task automatic t_halftone;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ht_we = 1'b1; ht_waddr = 4'(i); ht_wdata = (16'h1357 * 16'(i + 1)) ^ 16'(i << 12);
      htm[i] = (16'h1357 * 16'(i + 1)) ^ 16'(i << 12);
    end
    @(negedge clk);
    ht_we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      set_cfg(4'd0, 2'd1, 4'h3, 1'b0, 4'(i));
      calc("R8 halftone row by line number", 16'h0000, 16'hFFFF);
    end
  endtask

  task automatic t_forward;
    shift_in(16'hA1B2, 1'b1, 1'b0);
    shift_in(16'hC3D4, 1'b1, 1'b0);
    set_cfg(4'd0, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R2 forward load skew 0", 16'h5555, 16'hFFFF);
    set_cfg(4'd4, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R5 skew 4", 16'h5555, 16'hFFFF);
    set_cfg(4'd15, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R5 skew 15", 16'h5555, 16'hFFFF);
  endtask

  task automatic t_reverse;
    shift_in(16'h1E2F, 1'b1, 1'b1);
    shift_in(16'h7788, 1'b1, 1'b1);
    set_cfg(4'd0, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R3 reverse load low half", 16'h0000, 16'hFFFF);
    set_cfg(4'd8, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R3 reverse load skew 8", 16'h0000, 16'hFFFF);
  endtask

  task automatic t_flush;
    shift_in(16'h0F0F, 1'b1, 1'b0);
    shift_in(16'h9999, 1'b0, 1'b0);
    set_cfg(4'd0, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R4 flush keeps low half", 16'h0000, 16'hFFFF);
    set_cfg(4'd12, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R4 flush moved high half", 16'h0000, 16'hFFFF);
    shift_in(16'h4444, 1'b0, 1'b1);
    set_cfg(4'd0, 2'd2, 4'h3, 1'b0, 4'd0);
    calc("R4 reverse flush", 16'h0000, 16'hFFFF);
  endtask

  task automatic t_ops;
    shift_in(16'h0000, 1'b1, 1'b0);
    shift_in(16'hF0CC, 1'b1, 1'b0);
    for (int o = 0; o < 16; o++) begin
      set_cfg(4'd0, 2'd2, 4'(o), 1'b0, 4'd0);
      calc("R7 logic rule", 16'hAA3C, 16'hFFFF);
    end
  endtask

  task automatic t_hop;
    for (int h = 0; h < 4; h++) begin
      set_cfg(4'd2, 2'(h), 4'h6, 1'b0, 4'd9);
      calc("R6 halftone rule", 16'h6D21, 16'hFFFF);
    end
  endtask

  task automatic t_smudge;
    shift_in(16'h0000, 1'b1, 1'b0);
    shift_in(16'h00A5, 1'b1, 1'b0);
    set_cfg(4'd0, 2'd1, 4'h3, 1'b1, 4'd2);
    calc("R9 smudge nibble 5", 16'h0000, 16'hFFFF);
    check("R9 smudge row 5", new_dst, htm[5]);
    set_cfg(4'd4, 2'd1, 4'h3, 1'b1, 4'd2);
    calc("R9 smudge after skew", 16'h0000, 16'hFFFF);
    check("R9 smudge row A", new_dst, htm[10]);
    set_cfg(4'd0, 2'd3, 4'h3, 1'b1, 4'd7);
    calc("R9 smudge with and rule", 16'h0000, 16'hFFFF);
  endtask

  task automatic t_mask;
    set_cfg(4'd0, 2'd0, 4'hF, 1'b0, 4'd0);
    calc("R10 partial mask", 16'h1234, 16'h0FF0);
    check("R10 mask value", new_dst, 16'h1FF4);
    set_cfg(4'd0, 2'd2, 4'h6, 1'b0, 4'd0);
    calc("R10 zero mask", 16'hBEEF, 16'h0000);
    check("R10 zero mask keeps dst", new_dst, 16'hBEEF);
    calc("R10 single bit mask", 16'h8001, 16'h8000);
  endtask

  task automatic t_dontcare;
    logic [15:0] a;
    logic [3:0] ops [4] = '{4'h0, 4'h3, 4'hC, 4'hF};
    shift_in(16'h3C5A, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      set_cfg(4'd3, 2'd2, ops[k], 1'b0, 4'd0);
      calc("R11 dst all zero", 16'h0000, 16'hFFFF);
      a = new_dst;
      calc("R11 dst all one", 16'hFFFF, 16'hFFFF);
      check("R11 dst has no effect", new_dst, a);
    end
  endtask

  task automatic t_hold;
    logic [15:0] a;
    set_cfg(4'd0, 2'd2, 4'h6, 1'b0, 4'd0);
    calc("R12 update on strobe", 16'h0F0F, 16'hFFFF);
    a = new_dst;
    @(negedge clk);
    dst_word = 16'hFFFF; op = 4'hA;
    shift_in(16'h1111, 1'b1, 1'b0);
    @(negedge clk);
    check("R12 hold without strobe", new_dst, a);
    check("R12 valid low without strobe", {15'd0, new_dst_valid}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_shift = 1'b0; src_fill = 1'b0; src_rev = 1'b0; src_word = '0;
    set_cfg(4'd0, 2'd0, 4'h0, 1'b0, 4'd0);
    ht_we = 1'b0; ht_waddr = '0; ht_wdata = '0;
    calc_en = 1'b0; dst_word = '0; end_mask = '0;
    bm = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_halftone;
    t_forward;
    t_reverse;
    t_flush;
    t_ops;
    t_hop;
    t_smudge;
    t_mask;
    t_dontcare;
    t_hold;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule